// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler

This block picks at most one warp each clock cycle to send into a shared SIMD pipeline. Fairness comes from a rotating search. The search starts at the warp just after the one granted last and takes the first warp that can go. Every warp has two state bits. The in-flight bit is set when the warp is granted and cleared when its instruction retires. The blocked bit is set when the warp issues a long-latency memory request and cleared when that request completes.

A warp competes only when its valid input is high and both of its state bits are clear. Each warp can therefore have no more than one instruction in the pipeline. This removes the need for any dependency interlock or forwarding logic downstream. A warp that is waiting on memory drops out of arbitration, and the other warps keep issuing during that time. The grant leaves the block as a registered valid flag and a warp index. The default setting handles 32 warps of 32 threads each, which gives 1024 thread contexts.

Top module: `warp_issue_sched`

## Requirements
- R1: After synchronous reset, `issue_vld` is low, no warp is in flight or blocked, and the search pointer is at warp 0. If every warp is valid, the first grant goes to warp 0.
- R2: A warp is granted only when, in the cycle of the decision, its `warp_valid` bit is 1, its in-flight bit is 0 and its blocked bit is 0.
- R3: A grant decided from the inputs and state of cycle t shows up as `issue_vld`=1 and `issue_wid` in cycle t+1. There is never more than one grant per cycle.
- R4: Among eligible warps, the grant goes to the first one found by searching upward with wrap-around. The search starts at the index one above the last granted warp (index N-1 wraps to 0).
- R5: A granted warp is not granted again until a retire strobe names it. A retire applied in cycle t makes the warp eligible from cycle t+1, so its next grant appears in cycle t+2 at the earliest.
- R6: A memory-block strobe for a warp in cycle t removes that warp from arbitration from cycle t+1. A completion strobe for it in cycle t' returns it from cycle t'+1. Other warps keep being granted in the meantime.
- R7: If a block strobe and a completion strobe name the same warp in the same cycle, the warp ends up blocked. If a grant and a retire hit the same warp in the same cycle, the warp ends up in flight.
- R8: In a cycle with no eligible warp, `issue_vld` is 0 in the next cycle and the search pointer does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_valid | input | NUM_WARPS | Per-warp bit: the warp has an instruction ready |
| retire_stb | input | 1 | An instruction retires this cycle |
| retire_wid | input | WID_W | Warp index of the retiring instruction |
| memblk_stb | input | 1 | A warp sent a long-latency memory request |
| memblk_wid | input | WID_W | Warp index that is now waiting on memory |
| memdone_stb | input | 1 | A memory request completed |
| memdone_wid | input | WID_W | Warp index whose request completed |
| issue_vld | output | 1 | Registered: a warp is issued this cycle |
| issue_wid | output | WID_W | Registered: index of the issued warp |

## Verification
First, every warp is held valid with nothing retiring. This shows the rotation from warp 0 and that all grants stop once every warp is in flight. Next, all 256 valid masks of an eight-warp setup are swept, with each granted warp retired right after it issues. This separates correct wrap-around order from start-at-zero or fixed-priority mistakes. Directed memory-block sequences, including a block and a completion in the same cycle, check pool removal and which strobe wins. A long pseudo-random run with mixed retire, block and completion strobes checks all state interactions against an arithmetic model.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Next index after v in a ring of n entries.
  function automatic int unsigned ring_next(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/warp_flag_bank.sv
// One state bit per warp. A set strobe and a clear strobe each name a warp.
// When both name the same warp, set wins.
module warp_flag_bank #(
  parameter int NUM_WARPS = 32,
  parameter int WID_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_stb,
  input  logic [WID_W-1:0]     set_id,
  input  logic                 clr_stb,
  input  logic [WID_W-1:0]     clr_id,
  output logic [NUM_WARPS-1:0] flags
);

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[g] <= 1'b0;
      else if (set_stb && set_id == WID_W'(g))
        flags[g] <= 1'b1;
      else if (clr_stb && clr_id == WID_W'(g))
        flags[g] <= 1'b0;
    end
  end

  // R7: same-cycle set and clear on one warp leaves it set
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (set_stb && clr_stb && set_id == clr_id) |=> flags[$past(set_id)]);

  // R6: a lone clear removes the flag on the next cycle
  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !(set_stb && set_id == clr_id)) |=> !flags[$past(clr_id)]);

endmodule

// File: rtl/warp_rr_pick.sv
// Combinational rotating search: the first eligible warp at or after ptr.
module warp_rr_pick #(
  parameter int NUM_WARPS = 32,
  parameter int WID_W     = 5
) (
  input  logic [NUM_WARPS-1:0] elig,
  input  logic [WID_W-1:0]     ptr,
  output logic                 hit,
  output logic [WID_W-1:0]     sel
);

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      int idx;
      idx = int'(ptr) + i;
      if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
      if (!hit && elig[idx]) begin
        hit = 1'b1;
        sel = WID_W'(idx);
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_valid,
  input  logic                 retire_stb,
  input  logic [WID_W-1:0]     retire_wid,
  input  logic                 memblk_stb,
  input  logic [WID_W-1:0]     memblk_wid,
  input  logic                 memdone_stb,
  input  logic [WID_W-1:0]     memdone_wid,
  output logic                 issue_vld,
  output logic [WID_W-1:0]     issue_wid
);

  logic [NUM_WARPS-1:0] in_flight;
  logic [NUM_WARPS-1:0] mem_wait;
  logic [NUM_WARPS-1:0] elig;
  logic [WID_W-1:0]     rr_ptr;
  logic                 pick_hit;
  logic [WID_W-1:0]     pick_sel;

  assign elig = warp_valid & ~in_flight & ~mem_wait;

  warp_rr_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_pick (
    .elig (elig),
    .ptr  (rr_ptr),
    .hit  (pick_hit),
    .sel  (pick_sel)
  );

  // In-flight bit: set by a grant, cleared by retire
  warp_flag_bank #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_inflight (
    .clk     (clk),
    .rst     (rst),
    .set_stb (pick_hit),
    .set_id  (pick_sel),
    .clr_stb (retire_stb),
    .clr_id  (retire_wid),
    .flags   (in_flight)
  );

  // Memory-wait bit: set by a block strobe, cleared by completion
  warp_flag_bank #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_memwait (
    .clk     (clk),
    .rst     (rst),
    .set_stb (memblk_stb),
    .set_id  (memblk_wid),
    .clr_stb (memdone_stb),
    .clr_id  (memdone_wid),
    .flags   (mem_wait)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_vld <= 1'b0;
      issue_wid <= '0;
      rr_ptr    <= '0;
    end else begin
      issue_vld <= pick_hit;
      if (pick_hit) begin
        issue_wid <= pick_sel;
        rr_ptr    <= WID_W'(ring_next(int'(pick_sel), NUM_WARPS));
      end
    end
  end

  // Eligibility of the previous cycle, held only for the checks below
  logic [NUM_WARPS-1:0] elig_q;
  always_ff @(posedge clk) begin
    if (rst) elig_q <= '0;
    else     elig_q <= elig;
  end

  // R2: an issued warp was eligible in the decision cycle
  assert_granted_eligible_R2: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> elig_q[issue_wid]);

  // R5: one warp never issues in two consecutive cycles
  assert_no_reissue_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && $past(issue_vld)) |-> (issue_wid != $past(issue_wid)));

  // R8: no eligible warp means no grant in the next cycle
  assert_idle_no_grant_R8: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |=> !issue_vld);

  // R8: the search pointer does not move across an idle cycle
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |=> $stable(rr_ptr));

endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  valid;
  logic          ret_stb, blk_stb, done_stb;
  logic [IW-1:0] ret_id, blk_id, done_id;
  logic          issue_vld;
  logic [IW-1:0] issue_wid;

  always #2 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N), .WID_W(IW)) u0 (
    .clk         (clk),
    .rst         (rst),
    .warp_valid  (valid),
    .retire_stb  (ret_stb),
    .retire_wid  (ret_id),
    .memblk_stb  (blk_stb),
    .memblk_wid  (blk_id),
    .memdone_stb (done_stb),
    .memdone_wid (done_id),
    .issue_vld   (issue_vld),
    .issue_wid   (issue_wid)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // Independent model of the requirements
  bit [N-1:0] m_inf, m_blk;
  int         m_ptr;
  bit         e_vld;
  int         e_wid;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // Inputs are set before the call (at a negedge). Predict, clock, compare.
  task automatic tick(input string tag);
    bit [N-1:0] el;
    bit hit;
    int sel;
    el  = valid & ~m_inf & ~m_blk;
    hit = 0;
    sel = 0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (m_ptr + i) % N;
      if (!hit && el[k]) begin
        hit = 1;
        sel = k;
      end
    end
    if (ret_stb)  m_inf[ret_id]  = 1'b0;
    if (hit)      m_inf[sel]     = 1'b1;
    if (done_stb) m_blk[done_id] = 1'b0;
    if (blk_stb)  m_blk[blk_id]  = 1'b1;
    if (hit) m_ptr = (sel + 1) % N;
    e_vld = hit;
    if (hit) e_wid = sel;
    @(posedge clk);
    @(negedge clk);
    ret_stb  = 1'b0;
    blk_stb  = 1'b0;
    done_stb = 1'b0;
    nchk++;
    if (issue_vld !== e_vld || (e_vld && issue_wid !== IW'(e_wid))) begin
      nfail++;
      $display("FAIL %s: vld=%0b wid=%0d expected vld=%0b wid=%0d",
               tag, issue_vld, issue_wid, e_vld, e_wid);
    end
  endtask

  // Schedule a retire of whatever is visible on the issue port now
  task automatic follow_retire();
    if (issue_vld) begin
      ret_stb = 1'b1;
      ret_id  = issue_wid;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] r;
    rst = 1'b1; valid = '0;
    ret_stb = 0; blk_stb = 0; done_stb = 0;
    ret_id = '0; blk_id = '0; done_id = '0;
    m_inf = '0; m_blk = '0; m_ptr = 0; e_vld = 0; e_wid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    nchk++;
    if (issue_vld !== 1'b0) begin
      nfail++;
      $display("FAIL R1: vld=%0b expected 0 after reset", issue_vld);
    end

    // R1 R4: all valid, no retire -> 0..7 then stall (R8)
    valid = '1;
    for (int i = 0; i < N; i++) tick("R1 R4");
    tick("R8");
    // R5: retire warp 3, eligible one cycle later
    ret_stb = 1'b1; ret_id = 3'd3;
    tick("R5");
    tick("R5");
    tick("R5");
    for (int i = 0; i < N; i++) begin
      ret_stb = 1'b1; ret_id = IW'(i);
      tick("R5");
    end
    for (int i = 0; i < 4; i++) begin follow_retire(); tick("R5"); end

    // R2 R3 R4: sweep every valid mask with immediate retire
    for (int m = 0; m < (1 << N); m++) begin
      valid = N'(m);
      for (int t = 0; t < 12; t++) begin follow_retire(); tick("R2 R3 R4"); end
    end

    // R6: block warp 2, others keep going, then complete it
    valid = '1;
    blk_stb = 1'b1; blk_id = 3'd2;
    follow_retire(); tick("R6");
    for (int t = 0; t < 16; t++) begin follow_retire(); tick("R6"); end
    done_stb = 1'b1; done_id = 3'd2;
    follow_retire(); tick("R6");
    for (int t = 0; t < 16; t++) begin follow_retire(); tick("R6"); end

    // R7: block and completion on warp 5 together -> stays blocked
    blk_stb = 1'b1; blk_id = 3'd5; done_stb = 1'b1; done_id = 3'd5;
    follow_retire(); tick("R7");
    for (int t = 0; t < 16; t++) begin follow_retire(); tick("R7"); end
    done_stb = 1'b1; done_id = 3'd5;
    follow_retire(); tick("R7");
    for (int t = 0; t < 16; t++) begin follow_retire(); tick("R7"); end

    // R8: nothing valid, pointer holds, then resumes in order
    valid = '0;
    for (int t = 0; t < 4; t++) begin follow_retire(); tick("R8"); end
    valid = '1;
    for (int t = 0; t < 10; t++) begin follow_retire(); tick("R8"); end

    // R2 R3 R6 R7: pseudo-random mix of all strobes
    r = 16'hACE1;
    for (int t = 0; t < 3000; t++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      valid = r[7:0] | r[15:8];
      if (r[3]) follow_retire();
      else if (r[4]) begin ret_stb = 1'b1; ret_id = r[11:9]; end
      if (r[5] && r[6]) begin blk_stb = 1'b1; blk_id = r[14:12]; end
      if (r[7] || r[8]) begin done_stb = 1'b1; done_id = r[2:0]; end
      tick("R2 R3 R6 R7");
    end

    finished = 1;
    report();
  end

endmodule